// File: doc/BRIEF.md
# Cartridge Program-Bank Mapper

This block sits on the 8-bit CPU bus of a game cartridge and controls which part of a large program ROM and a banked work RAM the CPU sees. Software configures it by writing to a control window at 0x4800–0x4FFF. The two low address bits of such a write select one of four byte-wide control registers.

From those registers the block builds a full ROM address for any CPU address in 0x8000–0xFFFF, and a full RAM address for any CPU address in 0x6000–0x7FFF. It also drives a nametable mirroring select. Two program layouts are offered:

- A fixed-top layout. The lower 16K window is switchable and the upper 16K window is pinned to the last bank of the current outer group, or to one of its last two banks.
- A flat layout. This maps either one 16K bank into both halves or a single 32K bank.

The address outputs are combinational in the CPU address. Register writes land on the clock edge of the write strobe.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write with `cpu_we` high and `cpu_addr` in 0x4800–0x4FFF stores `cpu_wdata` into control register number `cpu_addr[1:0]` at that clock edge. Register 0 holds the mode bits, register 1 the inner bank, register 2 the outer bank and register 3 the RAM bank.
- R2: A strobe with the address outside 0x4800–0x4FFF, or an in-window address with `cpu_we` low, changes no register and no output.
- R3: After reset all four registers read as zero. The block is then in flat 32K layout with bank 0, RAM bank 0 and `mirror_sel` = 1.
- R4: The combined 16K bank is {register 2[7:0], register 1[2:0]}, an 11-bit number.
- R5: With register 0 bit 1 set (fixed-top layout), addresses 0x8000–0xBFFF give `rom_addr` = {combined bank, cpu_addr[13:0]}.
- R6: In fixed-top layout with register 0 bit 2 clear, 0xC000–0xFFFF gives `rom_addr` = {register 2, 3'b111, cpu_addr[13:0]}.
- R7: In fixed-top layout with register 0 bit 2 set, 0xC000–0xFFFF gives `rom_addr` = {register 2, 2'b11, register 1[0], cpu_addr[13:0]}.
- R8: With register 0 bit 1 clear and bit 2 set, both 16K halves give `rom_addr` = {combined bank, cpu_addr[13:0]}.
- R9: With register 0 bits 1 and 2 both clear, `rom_addr` = {combined bank[10:1], cpu_addr[14:0]} (one 32K bank).
- R10: `ram_addr` = {register 3[1:0], cpu_addr[12:0]}.
- R11: `mirror_sel` is the inverse of register 0 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| rom_addr | output | 25 | Program ROM byte address for 0x8000–0xFFFF |
| ram_addr | output | 15 | Work RAM byte address for 0x6000–0x7FFF |
| mirror_sel | output | 1 | Nametable mirroring select |

## Verification
The mapping is probed at low and high CPU addresses under each of the four layout codes, so that a swapped mode bit or a wrong window choice shows up as a different bank. The inner bank is set odd in flat 32K mode, which separates the shifted bank from the unshifted one. It is set both even and odd in half-fixed mode, which tests whether register 1 bit 0 reaches the upper window. Writes just below and just above the control window, writes with the strobe low, and writes to an aliased address near the top of the window check the address decode.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   // control register indices
   localparam int unsigned IDX_MODE  = 0;
   localparam int unsigned IDX_INNER = 1;
   localparam int unsigned IDX_OUTER = 2;
   localparam int unsigned IDX_RAM   = 3;
   localparam int unsigned NUM_REGS  = 4;
   // mode register bit positions
   localparam int unsigned MODE_MIRROR = 0;
   localparam int unsigned MODE_FIXED  = 1;
   localparam int unsigned MODE_HALF   = 2;

   typedef enum logic [1:0] {
      LAY_FLAT32  = 2'b00,
      LAY_FIXTOP  = 2'b01,
      LAY_FLAT16  = 2'b10,
      LAY_FIXPAIR = 2'b11
   } layout_e;
endpackage

// File: rtl/cbm_reg_file.sv
module cbm_reg_file #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 8,
   parameter logic [15:0] WIN_LO  = 16'h4800,
   parameter logic [15:0] WIN_HI  = 16'h4FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] regs_q [cbm_pkg::NUM_REGS]
);
   localparam int unsigned SEL_W = $clog2(cbm_pkg::NUM_REGS);

   if (ADDR_W < 16) begin : g_bad_addr
      $error("cbm_reg_file: ADDR_W must be at least 16");
   end

   logic             in_win;
   logic [SEL_W-1:0] sel;

   assign in_win = we && (addr >= ADDR_W'(WIN_LO)) && (addr <= ADDR_W'(WIN_HI));
   assign sel    = addr[SEL_W-1:0];

   for (genvar i = 0; i < cbm_pkg::NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs_q[i] <= '0;
         end else if (in_win && (sel == SEL_W'(i))) begin
            regs_q[i] <= wdata;
         end
      end
   end
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map #(
   parameter int unsigned INNER_W = 3,
   parameter int unsigned OUTER_W = 8,
   parameter int unsigned PAGE_W  = 14,
   localparam int unsigned BANK_W = OUTER_W + INNER_W,
   localparam int unsigned ROM_W  = BANK_W + PAGE_W
) (
   input  cbm_pkg::layout_e     layout,
   input  logic [INNER_W-1:0]   inner,
   input  logic [OUTER_W-1:0]   outer,
   input  logic [PAGE_W:0]      cpu_off,
   output logic [ROM_W-1:0]     rom_addr
);
   if (INNER_W < 2) begin : g_bad_inner
      $error("cbm_prg_map: INNER_W must be at least 2");
   end

   logic [BANK_W-1:0] comb_bank;
   logic [BANK_W-1:0] last_bank;
   logic [BANK_W-1:0] pair_bank;
   logic              upper;

   assign comb_bank = {outer, inner};
   assign last_bank = {outer, {INNER_W{1'b1}}};
   assign pair_bank = {outer, {(INNER_W-1){1'b1}}, inner[0]};
   assign upper     = cpu_off[PAGE_W];

   always_comb begin
      unique case (layout)
         cbm_pkg::LAY_FIXTOP:
            rom_addr = {(upper ? last_bank : comb_bank), cpu_off[PAGE_W-1:0]};
         cbm_pkg::LAY_FIXPAIR:
            rom_addr = {(upper ? pair_bank : comb_bank), cpu_off[PAGE_W-1:0]};
         cbm_pkg::LAY_FLAT16:
            rom_addr = {comb_bank, cpu_off[PAGE_W-1:0]};
         default:
            rom_addr = {comb_bank[BANK_W-1:1], cpu_off};
      endcase
   end
endmodule

// File: rtl/cbm_ram_map.sv
module cbm_ram_map #(
   parameter int unsigned RBANK_W = 2,
   parameter int unsigned RPAGE_W = 13,
   localparam int unsigned RAM_W  = RBANK_W + RPAGE_W
) (
   input  logic [RBANK_W-1:0] bank,
   input  logic [RPAGE_W-1:0] cpu_off,
   output logic [RAM_W-1:0]   ram_addr
);
   if (RBANK_W < 1) begin : g_bad_rbank
      $error("cbm_ram_map: RBANK_W must be at least 1");
   end
   assign ram_addr = {bank, cpu_off};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned INNER_W = 3,
   parameter int unsigned OUTER_W = 8,
   parameter int unsigned RBANK_W = 2,
   localparam int unsigned PAGE_W  = 14,
   localparam int unsigned RPAGE_W = 13,
   localparam int unsigned ROM_W   = OUTER_W + INNER_W + PAGE_W,
   localparam int unsigned RAM_W   = RBANK_W + RPAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [ROM_W-1:0]  rom_addr,
   output logic [RAM_W-1:0]  ram_addr,
   output logic              mirror_sel
);
   if (INNER_W > DATA_W || OUTER_W > DATA_W || RBANK_W > DATA_W) begin : g_bad_w
      $error("cart_bank_mapper: bank fields exceed register width");
   end

   logic [DATA_W-1:0] regs_q [cbm_pkg::NUM_REGS];
   logic [DATA_W-1:0] mode_q;
   cbm_pkg::layout_e  layout;

   cbm_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cpu_we), .addr(cpu_addr),
      .wdata(cpu_wdata), .regs_q(regs_q)
   );

   assign mode_q = regs_q[cbm_pkg::IDX_MODE];
   assign layout = cbm_pkg::layout_e'({mode_q[cbm_pkg::MODE_HALF],
                                       mode_q[cbm_pkg::MODE_FIXED]});

   cbm_prg_map #(.INNER_W(INNER_W), .OUTER_W(OUTER_W), .PAGE_W(PAGE_W)) u_prg (
      .layout(layout),
      .inner(regs_q[cbm_pkg::IDX_INNER][INNER_W-1:0]),
      .outer(regs_q[cbm_pkg::IDX_OUTER][OUTER_W-1:0]),
      .cpu_off(cpu_addr[PAGE_W:0]),
      .rom_addr(rom_addr)
   );

   cbm_ram_map #(.RBANK_W(RBANK_W), .RPAGE_W(RPAGE_W)) u_ram (
      .bank(regs_q[cbm_pkg::IDX_RAM][RBANK_W-1:0]),
      .cpu_off(cpu_addr[RPAGE_W-1:0]),
      .ram_addr(ram_addr)
   );

   assign mirror_sel = ~mode_q[cbm_pkg::MODE_MIRROR];
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_we,
   input logic [15:0] cpu_addr,
   input logic [7:0]  cpu_wdata,
   input logic [24:0] rom_addr,
   input logic [14:0] ram_addr,
   input logic        mirror_sel,
   input logic [7:0]  mode_q,
   input logic [7:0]  inner_q,
   input logic [7:0]  outer_q
);
   logic hit;
   assign hit = cpu_we && (cpu_addr >= 16'h4800) && (cpu_addr <= 16'h4FFF);

   // R11
   mirror_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cpu_addr[1:0] == 2'd0) |=> (mirror_sel == !$past(cpu_wdata[0])));

   // R10
   ram_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cpu_addr[1:0] == 2'd3) |=> (ram_addr[14:13] == $past(cpu_wdata[1:0])));

   // R2
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> ($stable(mirror_sel) && $stable(ram_addr[14:13])));

   // R6
   fixed_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && !mode_q[2] && cpu_addr[15:14] == 2'b11)
         |-> (rom_addr[24:14] == {outer_q, 3'b111}));

   // R8
   flat_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[1] && mode_q[2]) |-> (rom_addr[16:14] == inner_q[2:0]));

   // R9
   flat_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[1] && !mode_q[2]) |-> (rom_addr[14:0] == cpu_addr[14:0]));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
   .cpu_wdata(cpu_wdata), .rom_addr(rom_addr), .ram_addr(ram_addr),
   .mirror_sel(mirror_sel), .mode_q(regs_q[0]), .inner_q(regs_q[1]),
   .outer_q(regs_q[2])
);

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_wdata = 8'h00;
   logic [24:0] rom_addr;
   logic [14:0] ram_addr;
   logic        mirror_sel;

   always #5 clk = ~clk;

   cart_bank_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .rom_addr(rom_addr), .ram_addr(ram_addr),
      .mirror_sel(mirror_sel)
   );

   typedef struct {
      logic [24:0] rom;
      logic [14:0] ram;
      logic        mir;
      string       tag;
   } exp_t;

   exp_t        sb [$];
   logic [7:0]  m [4];
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   function automatic logic [24:0] model_rom(logic [15:0] a);
      logic [10:0] bank;
      logic [10:0] bank_last;
      logic [10:0] bank_pair;
      bank      = {m[2], m[1][2:0]};
      bank_last = {m[2], 3'b111};
      bank_pair = {m[2], 2'b11, m[1][0]};
      if (m[0][1]) begin
         if (!a[14])      return {bank, a[13:0]};
         else if (m[0][2]) return {bank_pair, a[13:0]};
         else             return {bank_last, a[13:0]};
      end else if (m[0][2]) begin
         return {bank, a[13:0]};
      end
      return {bank[10:1], a[14:0]};
   endfunction

   // driver: write one control register and update the model
   task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic we);
      @(posedge clk); #1;
      cpu_we = we; cpu_addr = a; cpu_wdata = d;
      @(posedge clk); #1;
      cpu_we = 1'b0;
      if (we && a >= 16'h4800 && a <= 16'h4FFF) m[a[1:0]] = d;
   endtask

   // driver: present a CPU address and queue the expected outputs
   task automatic probe(input logic [15:0] a, input string tag);
      exp_t e;
      @(posedge clk); #1;
      cpu_addr = a;
      e.rom = model_rom(a);
      e.ram = {m[3][1:0], a[12:0]};
      e.mir = ~m[0][0];
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk); #1;
   endtask

   // monitor: compare at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rom_addr !== e.rom || ram_addr !== e.ram || mirror_sel !== e.mir) begin
               fails++;
               $display("FAIL %s: rom=%h ram=%h mir=%b expected rom=%h ram=%h mir=%b",
                        e.tag, rom_addr, ram_addr, mirror_sel, e.rom, e.ram, e.mir);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) m[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R3: reset state
      probe(16'h8000, "R3 reset low");
      probe(16'hC123, "R3 reset high");
      probe(16'h6ABC, "R3 reset ram");
      // R1 R4 R5 R6: fixed-top layout
      bus_write(16'h4801, 8'h05, 1'b1);
      bus_write(16'h4802, 8'h2A, 1'b1);
      bus_write(16'h4800, 8'h02, 1'b1);
      probe(16'h8001, "R5 R4 fixed low");
      probe(16'hBFFF, "R5 fixed low top");
      probe(16'hC000, "R6 fixed last");
      probe(16'hFFFF, "R6 fixed last top");
      // R7: pair select with inner even then odd
      bus_write(16'h4800, 8'h06, 1'b1);
      bus_write(16'h4801, 8'h04, 1'b1);
      probe(16'hC010, "R7 pair even");
      bus_write(16'h4801, 8'h05, 1'b1);
      probe(16'hE010, "R7 pair odd");
      probe(16'h9000, "R7 R5 pair low");
      // R8: flat 16K
      bus_write(16'h4800, 8'h04, 1'b1);
      probe(16'h8123, "R8 flat16 low");
      probe(16'hC123, "R8 flat16 high");
      // R9: flat 32K with odd inner
      bus_write(16'h4800, 8'h00, 1'b1);
      probe(16'h8123, "R9 flat32 low");
      probe(16'hF123, "R9 flat32 high");
      // R10 and R1 alias near window top
      bus_write(16'h4FFF, 8'hFE, 1'b1);
      probe(16'h7FFF, "R10 R1 ram bank");
      bus_write(16'h4FFD, 8'h03, 1'b1);
      probe(16'h8000, "R1 alias inner");
      // R11: mirroring
      bus_write(16'h4800, 8'h01, 1'b1);
      probe(16'h6000, "R11 mirror set");
      bus_write(16'h4800, 8'h00, 1'b1);
      probe(16'h6000, "R11 mirror clear");
      // R2: ignored writes
      bus_write(16'h47FF, 8'hFF, 1'b1);
      bus_write(16'h5000, 8'hFF, 1'b1);
      bus_write(16'h4800, 8'hFF, 1'b0);
      bus_write(16'h4803, 8'hFF, 1'b0);
      probe(16'hC000, "R2 ignored rom");
      probe(16'h6000, "R2 ignored ram mir");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule